// File: doc/BRIEF.md
# Elastic-Buffer Jitter Smoother with Trimmed Read Divider

This block takes a single-bit data stream whose write strobes arrive unevenly (gapped, bursty or jittered) and turns it into an evenly paced output stream. Incoming bits are stored in a circular bit buffer. Output bits are released on a strobe made by dividing the fast system clock, nominally by 16. A 32.768 MHz clock then gives a 2.048 Mbit/s output. Software-free operation is intended: the only controls are a depth select, a pass-through (bypass) control and a clear for the sticky limit flag.

The buffer holds either 128 bits, which tolerates slow wander, or 32 bits, which keeps latency low. When the fill level drifts close to either end of the selected depth, the read divider is trimmed. It drops to 15 near full, so reads speed up, and rises to 17 near empty, so reads slow down. Any trimmed period latches a limit flag that stays set until it is cleared. After reset, after a depth change and while bypassed, the buffer is emptied. Reading then waits until the buffer is half full.

Everything runs in one clock domain. Write strobes are one cycle wide and already synchronous to that clock.

Top module: `jitter_fifo_atten`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, rd_stb, rd_bit and trip_flag are 0 and the buffer is empty.
- R2: deep_sel=1 selects a 128-bit buffer and deep_sel=0 a 32-bit buffer (the initial state after reset is the 128-bit setting). A change of deep_sel empties the buffer, ignores that cycle's write and restarts filling from empty.
- R3: No read strobe is produced until the fill level has reached half the selected depth. After that, with the fill strictly between the margin and depth minus the margin, reads occur every 16 clock cycles.
- R4: With a fill of at least depth minus margin, the read period is 15 cycles; with a fill of at most the margin, it is 17 cycles. The margin is 4 at depth 128 and 2 at depth 32. Back inside the band, the period returns to 16.
- R5: trip_flag becomes 1 after any cycle in which reading is active and the period is 15 or 17. It stays 1 until a trip_clr pulse clears it. A clear in the same cycle as a new trip leaves the flag at 1.
- R6: Bits leave in exactly the order they were accepted, for any spacing of write strobes.
- R7: A write that arrives when the buffer is full and no read happens in that cycle is discarded. A read slot that finds the buffer empty produces no strobe.
- R8: While bypass=1, rd_stb and rd_bit equal the wr_stb and wr_bit of the previous cycle, the buffer is emptied, and trip_flag is not set.
- R9: Outside bypass, rd_stb is a single-cycle pulse, and rd_bit changes only in a cycle where rd_stb is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock (nominally 32.768 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle write strobe for the incoming bit |
| wr_bit | input | 1 | Incoming data bit |
| deep_sel | input | 1 | 1 = 128-bit buffer, 0 = 32-bit buffer |
| bypass | input | 1 | 1 = pass input straight through, buffer held empty |
| trip_clr | input | 1 | One-cycle clear of the limit flag |
| rd_stb | output | 1 | One-cycle output bit strobe |
| rd_bit | output | 1 | Output data bit, valid with rd_stb |
| trip_flag | output | 1 | Sticky flag: read period was trimmed to 15 or 17 |

## Verification
On every cycle the assertions check that the fill never exceeds the selected depth, that the flag only rises after a trimmed period and holds until cleared, that bypass is a one-cycle pass-through, and that no read happens before priming. They also check that strobes are isolated pulses with the data bit held between them, and that the period is 16 whenever the fill sits inside the band. Bit ordering across gapped and bursty writes, the measured 15/16 cycle spacing, the discard of writes when full, the flush on a depth change, and the set-wins case of the flag can only be shown by the bench. It does this by running long write patterns at, above and below the nominal rate against a queue-based model.

// File: rtl/jfa_pkg.sv
package jfa_pkg;

   // Read-rate trim selected from the buffer fill level
   typedef enum logic [1:0] {
      RATE_NOM  = 2'd0,
      RATE_FAST = 2'd1,
      RATE_SLOW = 2'd2
   } rate_e;

   function automatic int fill_width(input int deep);
      return $clog2(deep + 1);
   endfunction

endpackage

// File: rtl/jfa_store.sv
module jfa_store #(
   parameter int DEEP    = 128,
   parameter int SHALLOW = 32,
   localparam int PW     = $clog2(DEEP),
   localparam int CW     = jfa_pkg::fill_width(DEEP)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          deep,
   input  logic          push,
   input  logic          push_bit,
   input  logic          pop,
   output logic [CW-1:0] fill,
   output logic          head_bit
);

   // elaboration-time parameter checks
   if (SHALLOW < 4 || SHALLOW >= DEEP) begin : g_bad_depth
      $error("jfa_store: SHALLOW must be at least 4 and below DEEP");
   end
   if ((1 << PW) != DEEP) begin : g_bad_pow2
      $error("jfa_store: DEEP must be a power of two");
   end

   logic [DEEP-1:0] cells;
   logic [PW-1:0]   wptr;
   logic [PW-1:0]   rptr;
   logic [CW-1:0]   cap;
   logic [PW-1:0]   last_idx;
   logic            accept;

   assign cap      = deep ? CW'(DEEP) : CW'(SHALLOW);
   assign last_idx = deep ? PW'(DEEP - 1) : PW'(SHALLOW - 1);

   // a write is taken when there is room, or a read frees a slot this cycle
   assign accept = push && !flush && ((fill < cap) || pop);

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p,
                                          input logic [PW-1:0] lim);
      return (p == lim) ? '0 : p + PW'(1);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         fill <= '0;
      end else if (flush) begin
         wptr <= '0;
         rptr <= '0;
         fill <= '0;
      end else begin
         if (accept) wptr <= bump(wptr, last_idx);
         if (pop)    rptr <= bump(rptr, last_idx);
         case ({accept, pop})
            2'b10:   fill <= fill + CW'(1);
            2'b01:   fill <= fill - CW'(1);
            default: fill <= fill;
         endcase
      end
   end

   // one storage cell per bit position, written only when addressed
   for (genvar g = 0; g < DEEP; g++) begin : g_cell
      always_ff @(posedge clk) begin
         if (accept && (wptr == PW'(g))) cells[g] <= push_bit;
      end
   end

   assign head_bit = cells[rptr];

endmodule

// File: rtl/jfa_rate.sv
module jfa_rate
   import jfa_pkg::*;
#(
   parameter int DEEP      = 128,
   parameter int SHALLOW   = 32,
   parameter int M_DEEP    = 4,
   parameter int M_SHALLOW = 2,
   parameter int P_NOM     = 16,
   parameter int P_FAST    = 15,
   parameter int P_SLOW    = 17,
   localparam int CW       = fill_width(DEEP),
   localparam int DW       = $clog2(P_SLOW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          deep,
   input  logic [CW-1:0] fill,
   output logic          pop,
   output logic          primed,
   output rate_e         rate,
   output logic [DW-1:0] period
);

   if (!(P_FAST < P_NOM && P_NOM < P_SLOW) || P_FAST < 2) begin : g_bad_period
      $error("jfa_rate: periods must satisfy 2 <= P_FAST < P_NOM < P_SLOW");
   end
   if (M_SHALLOW < 1 || 4 * M_SHALLOW >= SHALLOW) begin : g_bad_mshallow
      $error("jfa_rate: shallow margin must be below a quarter of SHALLOW");
   end
   if (M_DEEP < 1 || 4 * M_DEEP >= DEEP) begin : g_bad_mdeep
      $error("jfa_rate: deep margin must be below a quarter of DEEP");
   end

   logic [CW-1:0] cap;
   logic [CW-1:0] half;
   logic [CW-1:0] marg;
   logic [CW-1:0] hi_mark;
   logic [DW-1:0] dcnt;
   logic          slot;

   assign cap     = deep ? CW'(DEEP) : CW'(SHALLOW);
   assign half    = cap >> 1;
   assign marg    = deep ? CW'(M_DEEP) : CW'(M_SHALLOW);
   assign hi_mark = cap - marg;

   // trim decision from the distance to the selected limits
   always_comb begin
      rate = RATE_NOM;
      if (primed) begin
         if (fill >= hi_mark)   rate = RATE_FAST;
         else if (fill <= marg) rate = RATE_SLOW;
      end
   end

   always_comb begin
      case (rate)
         RATE_FAST: period = DW'(P_FAST);
         RATE_SLOW: period = DW'(P_SLOW);
         default:   period = DW'(P_NOM);
      endcase
   end

   // >= keeps the slot well defined when the period shrinks mid-count
   assign slot = (dcnt >= (period - DW'(1)));
   assign pop  = primed && !flush && slot && (fill != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed <= 1'b0;
         dcnt   <= '0;
      end else if (flush) begin
         primed <= 1'b0;
         dcnt   <= '0;
      end else begin
         if (fill >= half) primed <= 1'b1;
         if (!primed || slot) dcnt <= '0;
         else                 dcnt <= dcnt + DW'(1);
      end
   end

endmodule

// File: rtl/jfa_trip.sv
module jfa_trip (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);

   // set has priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag <= 1'b0;
      else if (set)  flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
   end

endmodule

// File: rtl/jitter_fifo_atten.sv
module jitter_fifo_atten
   import jfa_pkg::*;
#(
   parameter int DEEP      = 128,
   parameter int SHALLOW   = 32,
   parameter int M_DEEP    = 4,
   parameter int M_SHALLOW = 2,
   parameter int P_NOM     = 16,
   parameter int P_FAST    = 15,
   parameter int P_SLOW    = 17
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_stb,
   input  logic wr_bit,
   input  logic deep_sel,
   input  logic bypass,
   input  logic trip_clr,
   output logic rd_stb,
   output logic rd_bit,
   output logic trip_flag
);

   localparam int CW = fill_width(DEEP);
   localparam int DW = $clog2(P_SLOW + 1);

   logic          depth_q;
   logic          flush;
   logic          pop;
   logic          primed;
   logic          head_bit;
   logic [CW-1:0] fill;
   logic [DW-1:0] period;
   rate_e         rate;
   logic          trip_set;

   // a depth change or bypass empties the buffer and restarts priming
   assign flush = bypass || (deep_sel != depth_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) depth_q <= 1'b1;
      else        depth_q <= deep_sel;
   end

   jfa_store #(
      .DEEP    (DEEP),
      .SHALLOW (SHALLOW)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .deep     (depth_q),
      .push     (wr_stb),
      .push_bit (wr_bit),
      .pop      (pop),
      .fill     (fill),
      .head_bit (head_bit)
   );

   jfa_rate #(
      .DEEP      (DEEP),
      .SHALLOW   (SHALLOW),
      .M_DEEP    (M_DEEP),
      .M_SHALLOW (M_SHALLOW),
      .P_NOM     (P_NOM),
      .P_FAST    (P_FAST),
      .P_SLOW    (P_SLOW)
   ) u_rate (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (flush),
      .deep   (depth_q),
      .fill   (fill),
      .pop    (pop),
      .primed (primed),
      .rate   (rate),
      .period (period)
   );

   assign trip_set = primed && !flush && (rate != RATE_NOM);

   jfa_trip u_trip (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (trip_set),
      .clr   (trip_clr),
      .flag  (trip_flag)
   );

   // registered output stage, shared by the buffered and bypass paths
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_stb <= 1'b0;
         rd_bit <= 1'b0;
      end else if (bypass) begin
         rd_stb <= wr_stb;
         rd_bit <= wr_bit;
      end else begin
         rd_stb <= pop;
         if (pop) rd_bit <= head_bit;
      end
   end

endmodule

// File: rtl/jfa_checker.sv
module jfa_checker #(
   parameter int DEEP      = 128,
   parameter int SHALLOW   = 32,
   parameter int M_DEEP    = 4,
   parameter int M_SHALLOW = 2,
   parameter int P_NOM     = 16,
   localparam int CW       = jfa_pkg::fill_width(DEEP),
   localparam int DW       = $clog2(P_NOM + 2)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_stb,
   input logic          wr_bit,
   input logic          bypass,
   input logic          trip_clr,
   input logic          rd_stb,
   input logic          rd_bit,
   input logic          trip_flag,
   input logic          depth_q,
   input logic          primed,
   input logic [CW-1:0] fill,
   input logic [DW-1:0] period
);

   logic [CW-1:0] cap_c;
   logic [CW-1:0] marg_c;
   assign cap_c  = depth_q ? CW'(DEEP) : CW'(SHALLOW);
   assign marg_c = depth_q ? CW'(M_DEEP) : CW'(M_SHALLOW);

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= cap_c);

   // R5
   trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trip_flag && !trip_clr) |=> trip_flag);

   // R5
   trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trip_flag) |-> $past(primed && (period != DW'(P_NOM))));

   // R8
   bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |=> ((rd_stb == $past(wr_stb)) && (rd_bit == $past(wr_bit))));

   // R3
   prime_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && !primed) |=> !rd_stb);

   // R9
   strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !bypass) |=> !rd_stb);

   // R9
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stb && !$past(bypass)) |-> $stable(rd_bit));

   // R4
   band_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && (fill > marg_c) && (fill < (cap_c - marg_c)))
         |-> (period == DW'(P_NOM)));

endmodule

bind jitter_fifo_atten jfa_checker #(
   .DEEP      (DEEP),
   .SHALLOW   (SHALLOW),
   .M_DEEP    (M_DEEP),
   .M_SHALLOW (M_SHALLOW),
   .P_NOM     (P_NOM)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_stb    (wr_stb),
   .wr_bit    (wr_bit),
   .bypass    (bypass),
   .trip_clr  (trip_clr),
   .rd_stb    (rd_stb),
   .rd_bit    (rd_bit),
   .trip_flag (trip_flag),
   .depth_q   (depth_q),
   .primed    (primed),
   .fill      (fill),
   .period    (period)
);

// File: tb/sim_jitter_fifo_atten.sv
module sim_jitter_fifo_atten;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, wr_stb, wr_bit, deep_sel, bypass, trip_clr;
   logic rd_stb, rd_bit, trip_flag;

   jitter_fifo_atten u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (wr_stb),
      .wr_bit    (wr_bit),
      .deep_sel  (deep_sel),
      .bypass    (bypass),
      .trip_clr  (trip_clr),
      .rd_stb    (rd_stb),
      .rd_bit    (rd_bit),
      .trip_flag (trip_flag)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   // behavioural reference state
   bit m_q[$];
   bit m_primed, m_depth, m_trip, m_stb, m_bit;
   int m_dcnt;

   // strobe measurements on the real outputs
   int stb_count = 0;
   int last_stb = -1;
   int last_gap = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, exp);
      end
   endtask

   task automatic model_update();
      int cap, marg, cnt, div;
      bit rd, ntrip;
      if (!rst_n) begin
         m_q.delete();
         m_primed = 0; m_dcnt = 0; m_depth = 1;
         m_trip = 0; m_stb = 0; m_bit = 0;
         return;
      end
      cap  = m_depth ? 128 : 32;
      marg = m_depth ? 4 : 2;
      cnt  = m_q.size();
      div  = 16;
      rd   = 0;
      ntrip = m_trip && !trip_clr;
      if (bypass || (deep_sel != m_depth)) begin
         m_stb = bypass ? wr_stb : 1'b0;
         if (bypass) m_bit = wr_bit;
         m_q.delete();
         m_primed = 0;
         m_dcnt = 0;
         m_depth = deep_sel;
      end else begin
         if (m_primed) begin
            if (cnt >= cap - marg) div = 15;
            else if (cnt <= marg)  div = 17;
         end
         if (m_primed && div != 16) ntrip = 1;
         rd = m_primed && (m_dcnt >= div - 1) && (cnt > 0);
         m_stb = rd;
         if (rd) m_bit = m_q.pop_front();
         if (m_primed) m_dcnt = (m_dcnt >= div - 1) ? 0 : m_dcnt + 1;
         else          m_dcnt = 0;
         if (wr_stb && (cnt < cap || rd)) m_q.push_back(wr_bit);
         if (cnt >= cap / 2) m_primed = 1;
      end
      m_trip = ntrip;
   endtask

   task automatic step();
      model_update();
      @(posedge clk);
      #2;
      cyc++;
      chk(rd_stb == m_stb, "R3/R9 rd_stb", rd_stb, m_stb);
      chk(rd_bit == m_bit, "R6/R7 rd_bit", rd_bit, m_bit);
      chk(trip_flag == m_trip, "R5 trip_flag", trip_flag, m_trip);
      if (rd_stb) begin
         stb_count++;
         if (last_stb >= 0) last_gap = cyc - last_stb;
         last_stb = cyc;
      end
   endtask

   task automatic run(input int n, input int per, input int burst);
      for (int i = 0; i < n; i++) begin
         wr_stb = ((i % per) < burst);
         wr_bit = 1'($urandom());
         step();
      end
      wr_stb = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 0; wr_stb = 0; wr_bit = 0; deep_sel = 0; bypass = 0; trip_clr = 0;
      repeat (3) step();
      rst_n = 1;
      step();
      // R1 reset state
      chk(rd_stb == 0, "R1 rd_stb after reset", rd_stb, 0);
      chk(rd_bit == 0, "R1 rd_bit after reset", rd_bit, 0);
      chk(trip_flag == 0, "R1 trip_flag after reset", trip_flag, 0);

      // nominal rate, shallow buffer
      run(2000, 16, 1);
      stb_count = 0;
      run(320, 16, 1);
      chk(stb_count == 20, "R3 strobes per 320 cycles", stb_count, 20);
      chk(last_gap == 16, "R3 nominal spacing", last_gap, 16);

      // gapped, bursty writes at the same average rate
      run(1600, 64, 4);
      chk(trip_flag == 0, "R6 bursty writes within band", trip_flag, 0);

      // writes too fast: buffer saturates, period trims to 15
      run(3000, 14, 1);
      chk(trip_flag == 1, "R5 trip after fast input", trip_flag, 1);
      chk(last_gap == 15, "R4 spacing near full", last_gap, 15);
      trip_clr = 1;
      step();
      trip_clr = 0;
      chk(trip_flag == 1, "R5 clear with concurrent trip", trip_flag, 1);

      // back to nominal writes: fill returns into the band
      run(1200, 16, 1);
      trip_clr = 1;
      step();
      trip_clr = 0;
      chk(trip_flag == 0, "R5 clear takes effect", trip_flag, 0);
      run(300, 16, 1);
      chk(trip_flag == 0, "R4 band restores period 16", trip_flag, 0);
      chk(last_gap == 16, "R4 spacing back to 16", last_gap, 16);

      // writes too slow: buffer drains, period trims to 17
      run(4000, 19, 1);
      chk(trip_flag == 1, "R4 trip after slow input", trip_flag, 1);

      // switch to the deep buffer with a clear
      deep_sel = 1;
      trip_clr = 1;
      step();
      trip_clr = 0;
      chk(trip_flag == 0, "R2 flag cleared at depth change", trip_flag, 0);
      stb_count = 0;
      run(900, 16, 1);
      chk(stb_count == 0, "R2 no reads before half of 128", stb_count, 0);
      run(2400, 256, 16);
      chk(trip_flag == 0, "R2 deep buffer absorbs bursts", trip_flag, 0);

      // bypass: one-cycle pass-through
      bypass = 1;
      for (int i = 0; i < 300; i++) begin
         wr_stb = 1'($urandom());
         wr_bit = 1'($urandom());
         step();
         chk(rd_stb == wr_stb, "R8 bypass strobe", rd_stb, wr_stb);
         chk(rd_bit == wr_bit, "R8 bypass bit", rd_bit, wr_bit);
      end
      chk(trip_flag == 0, "R8 no trip in bypass", trip_flag, 0);
      bypass = 0;
      deep_sel = 0;
      wr_stb = 0;
      run(1000, 16, 1);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule